// File: doc/BRIEF.md
# Asynchronous Bus Read Handshake

This block is a bus master that reads memory over a bus with no common clock between master and slave. A read is issued on a local command port. The master drives an address and three strobes onto the bus: a memory-request qualifier, a read qualifier and a master-sync timing strobe. It then waits for the slave's sync strobe, captures the data lines and returns the word on a local response port. Every phase moves forward only when the partner's strobe edge arrives. The handshake is fully interlocked over four edges: the master strobe rises, the slave strobe rises, the master strobe falls, and the slave strobe falls.

A synthesizable memory slave is built into the same module so the handshake can be verified. It runs on its own clock and passes the master strobes through two-flop synchronizers. It answers only for addresses inside its window, reads a small constant array, drives the data lines with a separate output-enable and then raises its sync strobe. The master passes the slave strobe through its own two-flop synchronizer. It holds each phase for a minimum number of local clocks to model settling time, and it aborts with an error if no answer arrives within a timeout.

Top module: `async_read_link`

## Requirements
- R1: While either reset is active, and after it, cmd_ready is 1 and bus_mreq, bus_rd, bus_msyn, bus_ssyn, bus_data_oe and rsp_valid are 0, with bus_data equal to 0.
- R2: When a command is accepted (cmd_valid and cmd_ready at a master clock edge), bus_addr takes cmd_addr at that edge. No strobe is raised for the next SETUP edges, and bus_addr stays unchanged until the response is returned.
- R3: bus_mreq and bus_rd rise together exactly SETUP master edges after acceptance. bus_msyn rises SETUP edges after them, and bus_msyn is never high without bus_mreq and bus_rd.
- R4: For an address a below DEPTH, the slave raises bus_data_oe with bus_data = ((a*4951) XOR 42405) mod 2^DW at least one slave clock before it raises bus_ssyn, and keeps both unchanged while bus_ssyn is high. bus_data is 0 whenever bus_data_oe is 0.
- R5: Once the synchronized slave strobe is seen, the master gives a one-cycle rsp_valid with rsp_err 0 and rsp_data equal to the captured word. In that same cycle it drops bus_mreq, bus_rd and bus_msyn.
- R6: The slave lowers bus_ssyn only after bus_msyn is low, and it lowers bus_data_oe in the same slave cycle.
- R7: cmd_ready stays 0 from acceptance until the master has seen the slave strobe low, so commands offered meanwhile are not taken. cmd_ready is never 1 while bus_ssyn is high.
- R8: An address at or above DEPTH is not answered. After bus_msyn has been high for TMO master cycles, the master drops all strobes and gives rsp_valid with rsp_err 1 and rsp_data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk | input | 1 | Master local clock |
| m_rst_n | input | 1 | Master reset, active low |
| s_clk | input | 1 | Slave local clock |
| s_rst_n | input | 1 | Slave reset, active low |
| cmd_valid | input | 1 | Read command offered |
| cmd_addr | input | AW | Read address |
| cmd_ready | output | 1 | Master idle, command can be taken |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DW | Read word |
| rsp_err | output | 1 | Read timed out |
| bus_addr | output | AW | Address lines |
| bus_mreq | output | 1 | Memory-request qualifier |
| bus_rd | output | 1 | Read qualifier |
| bus_msyn | output | 1 | Master sync strobe |
| bus_ssyn | output | 1 | Slave sync strobe |
| bus_data_oe | output | 1 | Slave data drive enable |
| bus_data | output | DW | Data lines (0 when not driven) |

## Verification
The case that needs attention is a response arriving in the same cycle as a new command that is already waiting. The bench keeps cmd_valid high with the next address while a read completes. Its reference model checks, on every master clock, that cmd_ready stays low through the response cycle and through the slave's release. It then checks that the waiting command is taken only after the slave strobe has fallen, and that its phases start from that later acceptance edge. Timeouts and in-window reads are interleaved in the same way, so an error response and a waiting command also overlap.

// File: rtl/async_read_link.sv
module async_read_link #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int SETUP = 2,
  parameter int TMO   = 64
) (
  input  logic          m_clk,
  input  logic          m_rst_n,
  input  logic          s_clk,
  input  logic          s_rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  output logic          cmd_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic [AW-1:0] bus_addr,
  output logic          bus_mreq,
  output logic          bus_rd,
  output logic          bus_msyn,
  output logic          bus_ssyn,
  output logic          bus_data_oe,
  output logic [DW-1:0] bus_data
);
  localparam int CW = $clog2(SETUP + 1);
  localparam int TW = $clog2(TMO + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [2:0] {M_IDLE, M_ADDR, M_QUAL, M_SYNC, M_DONE} mst_t;
  typedef enum logic [1:0] {S_IDLE, S_DRIVE, S_ACK} slv_t;

  mst_t          m_st;
  logic [CW-1:0] ph_cnt;
  logic [TW-1:0] to_cnt;
  logic [1:0]    ssyn_sync;
  logic          qual_q, msyn_q;
  logic          ssyn_m;

  assign ssyn_m    = ssyn_sync[1];
  assign cmd_ready = (m_st == M_IDLE);
  assign bus_mreq  = qual_q;
  assign bus_rd    = qual_q;
  assign bus_msyn  = msyn_q;

  always_ff @(posedge m_clk or negedge m_rst_n) begin
    if (!m_rst_n) begin
      m_st      <= M_IDLE;
      ph_cnt    <= '0;
      to_cnt    <= '0;
      ssyn_sync <= '0;
      qual_q    <= 1'b0;
      msyn_q    <= 1'b0;
      bus_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      ssyn_sync <= {ssyn_sync[0], bus_ssyn};
      rsp_valid <= 1'b0;
      case (m_st)
        M_IDLE:
          if (cmd_valid) begin
            bus_addr <= cmd_addr;
            ph_cnt   <= '0;
            m_st     <= M_ADDR;
          end
        M_ADDR:
          if (ph_cnt == CW'(SETUP - 1)) begin
            ph_cnt <= '0;
            qual_q <= 1'b1;
            m_st   <= M_QUAL;
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        M_QUAL:
          if (ph_cnt == CW'(SETUP - 1)) begin
            ph_cnt <= '0;
            msyn_q <= 1'b1;
            to_cnt <= '0;
            m_st   <= M_SYNC;
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        M_SYNC:
          if (ssyn_m) begin
            rsp_valid <= 1'b1;
            rsp_data  <= bus_data;
            rsp_err   <= 1'b0;
            qual_q    <= 1'b0;
            msyn_q    <= 1'b0;
            m_st      <= M_DONE;
          end else if (to_cnt == TW'(TMO - 1)) begin
            rsp_valid <= 1'b1;
            rsp_data  <= '0;
            rsp_err   <= 1'b1;
            qual_q    <= 1'b0;
            msyn_q    <= 1'b0;
            m_st      <= M_DONE;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        M_DONE:
          if (!ssyn_m) m_st <= M_IDLE;
        default: m_st <= M_IDLE;
      endcase
    end
  end

  slv_t          s_st;
  logic [2:0]    strb_s1, strb_s2;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] data_q;
  logic          oe_q, ssyn_q;
  logic          hit;

  assign hit         = (int'(bus_addr) < DEPTH);
  assign bus_ssyn    = ssyn_q;
  assign bus_data_oe = oe_q;
  assign bus_data    = oe_q ? data_q : '0;

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      s_st    <= S_IDLE;
      strb_s1 <= '0;
      strb_s2 <= '0;
      data_q  <= '0;
      oe_q    <= 1'b0;
      ssyn_q  <= 1'b0;
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= DW'((i * 4951) ^ 42405);
    end else begin
      strb_s1 <= {bus_mreq, bus_rd, bus_msyn};
      strb_s2 <= strb_s1;
      case (s_st)
        S_IDLE:
          if (strb_s2 == 3'b111 && hit) begin
            data_q <= mem[bus_addr[IW-1:0]];
            oe_q   <= 1'b1;
            s_st   <= S_DRIVE;
          end
        S_DRIVE: begin
          ssyn_q <= 1'b1;
          s_st   <= S_ACK;
        end
        S_ACK:
          if (!strb_s2[0]) begin
            ssyn_q <= 1'b0;
            oe_q   <= 1'b0;
            data_q <= '0;
            s_st   <= S_IDLE;
          end
        default: s_st <= S_IDLE;
      endcase
    end
  end
endmodule

module async_read_link_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          m_clk,
  input logic          m_rst_n,
  input logic          s_clk,
  input logic          s_rst_n,
  input logic          cmd_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] bus_addr,
  input logic          bus_mreq,
  input logic          bus_rd,
  input logic          bus_msyn,
  input logic          bus_ssyn,
  input logic          bus_data_oe,
  input logic [DW-1:0] bus_data
);
  // R2
  addr_hold_chk: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    bus_mreq && $past(bus_mreq) |-> $stable(bus_addr));
  // R3
  msyn_qual_chk: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    bus_msyn |-> bus_mreq && bus_rd);
  // R5
  rsp_pulse_chk: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    rsp_valid |=> !rsp_valid);
  // R5
  rsp_release_chk: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    rsp_valid |-> !bus_mreq && !bus_rd && !bus_msyn);
  // R7
  ready_idle_chk: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    cmd_ready |-> !bus_mreq && !bus_msyn);
  // R4
  data_zero_chk: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    !bus_data_oe |-> bus_data == '0);
  // R4
  data_first_chk: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    $rose(bus_ssyn) |-> $past(bus_data_oe));
  // R4
  ssyn_drive_chk: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    bus_ssyn |-> bus_data_oe);
  // R6
  ssyn_release_chk: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    $fell(bus_ssyn) |-> !bus_msyn && !bus_data_oe);
endmodule

bind async_read_link async_read_link_chk #(.AW(AW), .DW(DW)) u_chk (
  .m_clk(m_clk), .m_rst_n(m_rst_n), .s_clk(s_clk), .s_rst_n(s_rst_n),
  .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .bus_addr(bus_addr),
  .bus_mreq(bus_mreq), .bus_rd(bus_rd), .bus_msyn(bus_msyn),
  .bus_ssyn(bus_ssyn), .bus_data_oe(bus_data_oe), .bus_data(bus_data)
);

// File: tb/test_async_read_link.sv
`timescale 1ns/100ps
module test_async_read_link;
  localparam int AW = 8, DW = 16, DEPTH = 16, SETUP = 2, TMO = 64;

  logic m_clk = 0, s_clk = 0, m_rst_n = 0, s_rst_n = 0;
  logic cmd_valid = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic cmd_ready, rsp_valid, rsp_err;
  logic [DW-1:0] rsp_data, bus_data;
  logic [AW-1:0] bus_addr;
  logic bus_mreq, bus_rd, bus_msyn, bus_ssyn, bus_data_oe;

  always #2.5 m_clk = ~m_clk;
  always #4 s_clk = ~s_clk;

  async_read_link #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .SETUP(SETUP), .TMO(TMO)) i_async_read_link (
    .m_clk(m_clk), .m_rst_n(m_rst_n), .s_clk(s_clk), .s_rst_n(s_rst_n),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .bus_addr(bus_addr), .bus_mreq(bus_mreq), .bus_rd(bus_rd), .bus_msyn(bus_msyn),
    .bus_ssyn(bus_ssyn), .bus_data_oe(bus_data_oe), .bus_data(bus_data));

  int total = 0, bad = 0, cyc = 0, acc_edge = 0, n_rsp = 0;
  bit busy = 0, prev_ssyn = 0, prev_oe = 0, done = 0;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] exp_q[$];

  function automatic logic [DW-1:0] word_of(input int a);
    return DW'((a * 4951) ^ 42405);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge m_clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      finish_run();
    end
  end

  always @(negedge m_clk) begin
    if (m_rst_n && s_rst_n) begin
      int k;
      k = cyc - acc_edge;
      if (busy) begin
        chk(!cmd_ready, "R7", cmd_ready, 0);
        chk(bus_addr == cur_addr, "R2", bus_addr, cur_addr);
        if (k < SETUP)
          chk(!bus_mreq && !bus_rd && !bus_msyn, "R2", {bus_mreq, bus_rd, bus_msyn}, 0);
        else if (k == SETUP)
          chk(bus_mreq && bus_rd && !bus_msyn, "R3", {bus_mreq, bus_rd, bus_msyn}, 3'b110);
        else if (k == 2 * SETUP)
          chk(bus_mreq && bus_rd && bus_msyn, "R3", {bus_mreq, bus_rd, bus_msyn}, 3'b111);
      end
      chk(!bus_msyn || (bus_mreq && bus_rd), "R3", {bus_mreq, bus_rd, bus_msyn}, 3'b111);
      if (rsp_valid) begin
        n_rsp++;
        if (exp_q.size() == 0) begin
          chk(0, "R5", 1, 0);
        end else begin
          logic [AW-1:0] a;
          a = exp_q.pop_front();
          if (int'(a) < DEPTH) begin
            chk(!rsp_err && rsp_data == word_of(a), "R5", {rsp_err, rsp_data}, {1'b0, word_of(a)});
          end else begin
            chk(rsp_err && rsp_data == 0, "R8", {rsp_err, rsp_data}, {1'b1, 16'h0});
            chk(k == 2 * SETUP + TMO, "R8", k, 2 * SETUP + TMO);
          end
        end
        chk(!bus_mreq && !bus_rd && !bus_msyn, "R5", {bus_mreq, bus_rd, bus_msyn}, 0);
        busy = 0;
      end
      chk(bus_data_oe || bus_data == 0, "R4", bus_data, 0);
      if (bus_ssyn) begin
        chk(bus_data_oe && bus_data == word_of(bus_addr), "R4", bus_data, word_of(bus_addr));
        chk(int'(bus_addr) < DEPTH, "R8", bus_addr, DEPTH);
      end
      if (bus_ssyn && !prev_ssyn) chk(prev_oe, "R4", prev_oe, 1);
      if (!bus_ssyn && prev_ssyn)
        chk(!bus_msyn && !bus_data_oe, "R6", {bus_msyn, bus_data_oe}, 0);
      chk(!(cmd_ready && bus_ssyn), "R7", {cmd_ready, bus_ssyn}, 0);
      if (cmd_valid && cmd_ready) begin
        chk(!busy, "R7", busy, 0);
        busy = 1;
        acc_edge = cyc + 1;
        cur_addr = cmd_addr;
        exp_q.push_back(cmd_addr);
      end
      prev_ssyn = bus_ssyn;
      prev_oe = bus_data_oe;
    end
  end

  task automatic reset_state_check();
    @(negedge m_clk);
    chk(cmd_ready && !rsp_valid, "R1", {cmd_ready, rsp_valid}, 2'b10);
    chk(!bus_mreq && !bus_rd && !bus_msyn, "R1", {bus_mreq, bus_rd, bus_msyn}, 0);
    chk(!bus_ssyn && !bus_data_oe && bus_data == 0, "R1", {bus_ssyn, bus_data_oe, bus_data}, 0);
  endtask

  task automatic issue(input logic [AW-1:0] a);
    bit acc;
    @(posedge m_clk); #1;
    cmd_valid = 1; cmd_addr = a;
    do begin
      @(negedge m_clk); acc = cmd_ready;
      @(posedge m_clk);
    end while (!acc);
    #1 cmd_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      @(negedge m_clk);
      if (!busy && cmd_ready && exp_q.size() == 0) break;
    end
  endtask

  initial begin
    int sent;
    sent = 0;
    reset_state_check();
    repeat (4) @(posedge m_clk);
    #1 m_rst_n = 1; s_rst_n = 1;
    reset_state_check();
    reset_state_check();
    // R5 single in-window reads at both window ends
    issue(8'd0); sent++; drain();
    issue(8'(DEPTH - 1)); sent++; drain();
    // R8 first address outside the window, and the top address
    issue(8'(DEPTH)); sent++; drain();
    issue(8'hFF); sent++; drain();
    // R7 back-to-back: valid held while the previous read completes
    issue(8'd3); issue(8'd7); issue(8'd9); issue(8'd40); issue(8'd12); sent += 5;
    drain();
    for (int a = 0; a < DEPTH; a++) begin
      issue(8'(a)); sent++;
    end
    drain();
    chk(n_rsp == sent, "R5", n_rsp, sent);
    reset_state_check();
    chk(cmd_ready && !bus_ssyn, "R7", {cmd_ready, bus_ssyn}, 2'b10);
    finish_run();
  end
endmodule